// File: doc/BRIEF.md
# Not-Taken Branch Exception Table

This block predicts the direction of conditional branches by remembering the exceptions rather than keeping counters. A small fully associative table holds the addresses of branches whose latest resolved outcome was not taken. Any branch found in the table is predicted not taken. Any branch that is absent is predicted taken.

Two ports drive the table. The lookup port takes a branch address and returns a combinational prediction in the same cycle. If the lookup is flagged as valid and hits, the entry becomes the most recently used. The resolve port reports the real outcome of a branch. A not-taken outcome inserts the branch, or refreshes it if it is already present. A taken outcome removes the branch if it is present. When the table is full, insertion replaces the least recently used entry. The LRU order is exact and is kept as one rank per entry.

Top module: `nt_branch_table`

## Requirements
- R1: After reset every entry is invalid, so `pred_taken_o` is 1 for every lookup address.
- R2: `pred_taken_o` is 0 exactly when `lkp_pc_i` equals the tag of a valid entry. It is combinational and independent of `lkp_valid_i`.
- R3: A resolve with `rsv_taken_i`=0 for an address that is absent inserts that address as most recently used. Lookups of it predict not taken from the next cycle.
- R4: A resolve with `rsv_taken_i`=0 for an address that is already present only moves it to most recently used. No second copy is made and no entry is evicted.
- R5: A resolve with `rsv_taken_i`=1 for an address that is present removes it. Lookups of it predict taken from the next cycle.
- R6: A resolve with `rsv_taken_i`=1 for an address that is absent changes neither the contents nor the LRU order.
- R7: An insertion uses an invalid entry whenever one exists, so no valid address is lost while the table is not full.
- R8: An insertion into a full table evicts the least recently used address.
- R9: A lookup with `lkp_valid_i`=1 that hits makes that entry most recently used. A lookup with `lkp_valid_i`=0 leaves the LRU order unchanged.
- R10: When `rsv_valid_i` and `lkp_valid_i` are both 1 in one cycle, the resolve is applied and the LRU update from the lookup is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup is a real fetch; allows the LRU update on a hit |
| lkp_pc_i | input | TAG_W | Address of the branch being looked up |
| pred_taken_o | output | 1 | Prediction: 1 taken (miss), 0 not taken (hit) |
| rsv_valid_i | input | 1 | A resolved outcome is present |
| rsv_pc_i | input | TAG_W | Address of the resolved branch |
| rsv_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench uses four entries and four-bit addresses. After every operation it probes all sixteen addresses with `lkp_valid_i` low, so the whole contents are observed without disturbing them. The expected contents come from an ordered recency list kept in the bench.

The bench targets several corner cases. Refreshing a present entry must not evict anything; a design that inserts a duplicate would lose an address early. A taken resolve of an absent address must not perturb the LRU order; if it did, a later eviction would remove the wrong address. A hitting lookup must protect its entry from the next eviction, while a probe lookup must not. A collision between a resolve and a lookup must drop the lookup's touch; if it did not, the wrong victim would appear after the next fill.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int unsigned MAX_ENTRIES = 64;

  // lowest set bit index of a vector, 0 when empty
  function automatic int unsigned low_idx(input logic [MAX_ENTRIES-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/nbt_match.sv
module nbt_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 16
) (
  input  logic [N-1:0][TAG_W-1:0] tag_i,
  input  logic [N-1:0]            valid_i,
  input  logic [TAG_W-1:0]        pc_i,
  output logic [N-1:0]            hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tag_i[g] == pc_i);
  end
endmodule

// File: rtl/nbt_lru.sv
module nbt_lru #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      touch_i,
  input  logic [IDX_W-1:0]          touch_idx_i,
  output logic [N-1:0][IDX_W-1:0]   rank_o,
  output logic [IDX_W-1:0]          lru_idx_o
);
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [IDX_W-1:0]        ref_rank;

  assign ref_rank = rank_q[touch_idx_i];
  assign rank_o   = rank_q;

  // rank 0 = most recent, N-1 = least recent; ranks stay a permutation
  for (genvar g = 0; g < N; g++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))  rank_q[g] <= '0;
        else if (rank_q[g] < ref_rank) rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_q[i] == IDX_W'(N - 1)) lru_idx_o = IDX_W'(i);
    end
  end

  // every rank value owned by exactly one entry (supports R8 victim choice)
  for (genvar r = 0; r < N; r++) begin : g_chk
    logic [N-1:0] own;
    for (genvar e = 0; e < N; e++) begin : g_own
      assign own[e] = (rank_q[e] == IDX_W'(r));
    end
    p_rank_unique_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(own) == 1);
  end

  p_touch_mru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> rank_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/nbt_victim.sv
module nbt_victim #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid_i,
  input  logic [IDX_W-1:0] lru_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  import nbt_pkg::*;
  logic [MAX_ENTRIES-1:0] free_ext;

  assign free_ext = MAX_ENTRIES'(~valid_i);
  assign victim_o = (&valid_i) ? lru_idx_i : IDX_W'(low_idx(free_ext));
endmodule

// File: rtl/nt_branch_table.sv
module nt_branch_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [TAG_W-1:0] lkp_pc_i,
  output logic             pred_taken_o,
  input  logic             rsv_valid_i,
  input  logic [TAG_W-1:0] rsv_pc_i,
  input  logic             rsv_taken_i
);
  import nbt_pkg::*;

  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            lkp_hit, rsv_hit;
  logic [ENTRIES-1:0][IDX_W-1:0] rank;
  logic [IDX_W-1:0]              lkp_idx, rsv_idx, vic_idx, lru_idx, wr_idx, touch_idx;
  logic                          rsv_any, ins, purge, touch;

  // two CAM ports over the same storage
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [TAG_W-1:0]   pc;
    logic [ENTRIES-1:0] hv;
    assign pc = (p == 0) ? lkp_pc_i : rsv_pc_i;
    nbt_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_match (
      .tag_i(tag_q), .valid_i(valid_q), .pc_i(pc), .hit_o(hv));
  end
  assign lkp_hit = g_port[0].hv;
  assign rsv_hit = g_port[1].hv;

  assign lkp_idx = IDX_W'(low_idx(MAX_ENTRIES'(lkp_hit)));
  assign rsv_idx = IDX_W'(low_idx(MAX_ENTRIES'(rsv_hit)));
  assign rsv_any = |rsv_hit;

  assign pred_taken_o = ~|lkp_hit;

  nbt_victim #(.N(ENTRIES)) u_victim (
    .valid_i(valid_q), .lru_idx_i(lru_idx), .victim_o(vic_idx));

  assign ins    = rsv_valid_i && !rsv_taken_i;
  assign purge  = rsv_valid_i && rsv_taken_i && rsv_any;
  assign wr_idx = rsv_any ? rsv_idx : vic_idx;

  // resolve wins over a lookup touch in the same cycle
  assign touch     = ins || (!rsv_valid_i && lkp_valid_i && |lkp_hit);
  assign touch_idx = ins ? wr_idx : lkp_idx;

  nbt_lru #(.N(ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch), .touch_idx_i(touch_idx),
    .rank_o(rank), .lru_idx_o(lru_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (ins) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= rsv_pc_i;
    end else if (purge) begin
      valid_q[rsv_idx] <= 1'b0;
    end
  end

  p_no_dup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsv_hit) && $onehot0(lkp_hit));

  p_insert_mru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(rsv_pc_i)
            && rank[$past(wr_idx)] == '0);

  p_purge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_valid_i && rsv_taken_i) |=> (valid_q & $past(rsv_hit)) == '0);

  p_fill_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins && !rsv_any && !(&valid_q)) |=>
      $countones(valid_q) == $past($countones(valid_q)) + 1);

  p_absent_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_valid_i && rsv_taken_i && !rsv_any) |=> $stable(valid_q) && $stable(rank));
endmodule

// File: tb/tb_nt_branch_table.sv
`timescale 1ns/1ps
module tb_nt_branch_table;
  localparam int E  = 4;
  localparam int TW = 4;
  localparam int NPC = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkp_valid = 1'b0, rsv_valid = 1'b0, rsv_taken = 1'b0;
  logic [TW-1:0] lkp_pc = '0, rsv_pc = '0;
  logic pred_taken;

  int n_chk = 0, n_bad = 0;
  int lst[E];  // recency list, index 0 = most recent
  int n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nt_branch_table #(.ENTRIES(E), .TAG_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc),
    .pred_taken_o(pred_taken), .rsv_valid_i(rsv_valid), .rsv_pc_i(rsv_pc),
    .rsv_taken_i(rsv_taken));

  function automatic int find(input int pc);
    for (int i = 0; i < n; i++) if (lst[i] == pc) return i;
    return -1;
  endfunction

  task automatic drop(input int pos);
    for (int i = pos; i < n - 1; i++) lst[i] = lst[i+1];
    n--;
  endtask

  task automatic push_front(input int pc);
    for (int i = n; i > 0; i--) lst[i] = lst[i-1];
    lst[0] = pc;
    n++;
  endtask

  task automatic check(input string req, input logic act, input logic exp, input int pc);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%0d pred_taken act=%0b exp=%0b", req, pc, act, exp);
    end
  endtask

  task automatic probe_all(input string req);
    lkp_valid = 1'b0;
    for (int p = 0; p < NPC; p++) begin
      lkp_pc = TW'(p);
      #1;
      check(req, pred_taken, (find(p) < 0), p);
    end
  endtask

  // one cycle of stimulus, then model update and a full probe
  task automatic op(input string req, input bit lv, input int lpc,
                    input bit rv, input int rpc, input bit rt);
    int pos;
    @(negedge clk);
    lkp_valid = lv; lkp_pc = TW'(lpc);
    rsv_valid = rv; rsv_pc = TW'(rpc); rsv_taken = rt;
    #1;
    if (lv) check({req, " R2"}, pred_taken, (find(lpc) < 0), lpc);
    @(posedge clk);
    #1;
    lkp_valid = 0; rsv_valid = 0; rsv_taken = 0;
    if (rv) begin
      pos = find(rpc);
      if (!rt) begin
        if (pos >= 0) drop(pos);
        else if (n == E) n--;
        push_front(rpc);
      end else if (pos >= 0) drop(pos);
    end else if (lv) begin
      pos = find(lpc);
      if (pos >= 0) begin drop(pos); push_front(lpc); end
    end
    probe_all(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    probe_all("R1 reset");
    // R7: fill free slots, none lost
    op("R3 insert", 0, 0, 1, 3, 0);
    op("R7 fill", 0, 0, 1, 5, 0);
    op("R7 fill", 0, 0, 1, 9, 0);
    op("R7 fill", 0, 0, 1, 12, 0);
    // R4: refresh oldest, then insert evicts next oldest (5)
    op("R4 refresh", 0, 0, 1, 3, 0);
    op("R8 evict", 0, 0, 1, 1, 0);
    // R9: valid hit protects 9; probe lookup does not protect 12
    op("R9 touch", 1, 9, 0, 0, 0);
    op("R9 probe", 0, 12, 0, 0, 0);
    op("R8 evict", 0, 0, 1, 2, 0);
    // R6: taken on absent changes nothing
    op("R6 absent", 0, 0, 1, 14, 1);
    op("R8 evict", 0, 0, 1, 4, 0);
    // R5: purge then refill uses the hole
    op("R5 purge", 0, 0, 1, 1, 1);
    op("R7 hole", 0, 0, 1, 7, 0);
    // R10: collision, touch dropped
    op("R10 both", 1, 2, 1, 11, 0);
    op("R10 after", 0, 0, 1, 13, 0);
    // sweep
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 2);
      op("sweep", (sel != 1) ? bit'($urandom_range(0, 1)) : 1'b0, $urandom_range(0, 7),
         sel != 0, $urandom_range(0, 7), bit'($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule